// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This block keeps the four condition bits of a 64-bit integer core (negative, zero, carry, overflow) and decides whether the branch in the execute stage is taken. The adder or logic unit supplies its result, its carry out of the top bit and its signed-overflow indication. The decoder supplies a flag-write enable for the flag-setting variants of add, subtract and AND, register and immediate forms alike. When the enable is high, the four bits are captured at the next clock edge. Every other instruction leaves them as they were.

For a branch, the decoder gives a branch kind and, for conditional branches, a condition code. A conditional branch tests the stored bits with either a signed or an unsigned predicate. Compare-and-branch tests a register operand for zero and does not look at the stored bits. An unconditional branch is always taken. The decision is combinational and reads the bits held at the start of the cycle, so a branch in the cycle after a flag-setting instruction sees that instruction's result. Target arithmetic and the ALU are outside this block.

Top module: `cond_branch_unit`

## Requirements
- R1: When `flag_set_i` is high at a rising edge, the stored N bit becomes bit 63 of `alu_res_i`, and the stored Z bit becomes 1 exactly when `alu_res_i` is all zeros.
- R2: When `flag_set_i` is high at a rising edge, the stored C bit becomes `alu_cout_i` and the stored V bit becomes `alu_ovf_i`. For a subtract, C is therefore the inverse of borrow.
- R3: When `flag_set_i` is low at a rising edge, all four stored bits keep their values whatever the ALU inputs carry.
- R4: Reset (`rst_n` low, asynchronous assertion, release synchronised over two clock edges) clears all four bits. After reset, EQ is not taken, NE is taken, LO is taken, GE is taken and LT is not taken.
- R5: With `br_type_i` = 4 (conditional), the signed codes are decided as follows: 0 EQ taken if Z; 1 NE taken if not Z; 6 GE taken if N equals V; 7 LT taken if N differs from V; 8 GT taken if not Z and N equals V; 9 LE taken if Z or N differs from V.
- R6: With `br_type_i` = 4, the unsigned codes are decided as follows: 2 HS taken if C; 3 LO taken if not C; 4 HI taken if C and not Z; 5 LS taken if not C or Z. After a subtract of one from all-ones, LT and HI are both taken.
- R7: With `br_type_i` = 4, condition codes 10 to 15 are never taken.
- R8: `br_type_i` = 1 is always taken. `br_type_i` = 2 is taken exactly when all 64 bits of `reg_opnd_i` are zero, and `br_type_i` = 3 exactly when they are not. Neither depends on the stored bits. Kinds 0, 5, 6 and 7 are never taken.
- R9: A conditional branch in the same cycle as a flag write is decided on the bits stored before that write. The new bits affect branches from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| alu_res_i | input | 64 | Result from the adder/logic unit |
| alu_cout_i | input | 1 | Carry out of the most significant bit |
| alu_ovf_i | input | 1 | Signed overflow of the operation |
| flag_set_i | input | 1 | Current instruction writes the condition bits |
| cond_i | input | 4 | Condition code for a conditional branch |
| br_type_i | input | 3 | Branch kind: 0 none, 1 always, 2 on zero, 3 on nonzero, 4 conditional |
| reg_opnd_i | input | 64 | Register operand tested by compare-and-branch |
| taken_o | output | 1 | Branch taken decision |

## Verification
The flag write and the conditional-branch decision can fall in the same cycle: a flag-setting instruction and a branch are presented together. The bench provokes this by raising `flag_set_i` with a result whose zero bit disagrees with the stored one, while an EQ branch is presented. It judges the decision against the old Z before the edge and against the new Z once the edge has passed. An assertion also ties the EQ decision to the stored bit on every cycle in which both happen.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam int CC_W = 4;
  localparam int BR_W = 3;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzvc_t;

  typedef enum logic [CC_W-1:0] {
    CC_EQ = 4'd0,
    CC_NE = 4'd1,
    CC_HS = 4'd2,
    CC_LO = 4'd3,
    CC_HI = 4'd4,
    CC_LS = 4'd5,
    CC_GE = 4'd6,
    CC_LT = 4'd7,
    CC_GT = 4'd8,
    CC_LE = 4'd9
  } cc_e;

  localparam logic [CC_W-1:0] CC_LAST_VALID = 4'd9;

  typedef enum logic [BR_W-1:0] {
    BR_NONE    = 3'd0,
    BR_ALWAYS  = 3'd1,
    BR_ZERO    = 3'd2,
    BR_NONZERO = 3'd3,
    BR_COND    = 3'd4
  } br_e;

endpackage

// File: rtl/cbu_rst_sync.sv
module cbu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/cbu_zero_det.sv
module cbu_zero_det #(
  parameter int W     = 64,
  parameter int SEG_W = 8
) (
  input  logic [W-1:0] vec_i,
  output logic         zero_o
);
  localparam int NSEG  = (W + SEG_W - 1) / SEG_W;
  localparam int PAD_W = NSEG * SEG_W;

  logic [PAD_W-1:0] padded;
  logic [NSEG-1:0]  seg_any;

  always_comb begin
    padded          = '0;
    padded[W-1:0]   = vec_i;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_any[s] = |padded[s*SEG_W +: SEG_W];
  end

  assign zero_o = ~|seg_any;
endmodule

// File: rtl/cbu_flag_gen.sv
module cbu_flag_gen
  import cbu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              cout_i,
  input  logic              ovf_i,
  output nzvc_t             flags_o
);
  logic res_zero;

  cbu_zero_det #(.W(DATA_W), .SEG_W(SEG_W)) u_res_zero (
    .vec_i  (res_i),
    .zero_o (res_zero)
  );

  always_comb begin
    flags_o.n = res_i[DATA_W-1];
    flags_o.z = res_zero;
    flags_o.c = cout_i;
    flags_o.v = ovf_i;
  end
endmodule

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg
  import cbu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_en_i,
  input  nzvc_t flags_new_i,
  output nzvc_t flags_q
);
  nzvc_t flags_nxt;

  always_comb begin
    flags_nxt = flags_q;
    if (set_en_i) flags_nxt = flags_new_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nxt;
  end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
(
  input  nzvc_t           flags_i,
  input  logic [CC_W-1:0] cond_i,
  output logic            pass_o
);
  logic sgn_ge;

  assign sgn_ge = (flags_i.n == flags_i.v);

  always_comb begin
    pass_o = 1'b0;
    case (cond_i)
      CC_EQ:   pass_o = flags_i.z;
      CC_NE:   pass_o = ~flags_i.z;
      CC_HS:   pass_o = flags_i.c;
      CC_LO:   pass_o = ~flags_i.c;
      CC_HI:   pass_o = flags_i.c & ~flags_i.z;
      CC_LS:   pass_o = ~flags_i.c | flags_i.z;
      CC_GE:   pass_o = sgn_ge;
      CC_LT:   pass_o = ~sgn_ge;
      CC_GT:   pass_o = ~flags_i.z & sgn_ge;
      CC_LE:   pass_o = flags_i.z | ~sgn_ge;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_cout_i,
  input  logic              alu_ovf_i,
  input  logic              flag_set_i,
  input  logic [CC_W-1:0]   cond_i,
  input  logic [BR_W-1:0]   br_type_i,
  input  logic [DATA_W-1:0] reg_opnd_i,
  output logic              taken_o
);
  logic  rst_q_n;
  nzvc_t flags_new;
  nzvc_t flags_q;
  logic  cond_pass;
  logic  opnd_zero;

  cbu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cbu_flag_gen #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_flag_gen (
    .res_i   (alu_res_i),
    .cout_i  (alu_cout_i),
    .ovf_i   (alu_ovf_i),
    .flags_o (flags_new)
  );

  cbu_flag_reg u_flag_reg (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .set_en_i    (flag_set_i),
    .flags_new_i (flags_new),
    .flags_q     (flags_q)
  );

  cbu_cond_eval u_cond_eval (
    .flags_i (flags_q),
    .cond_i  (cond_i),
    .pass_o  (cond_pass)
  );

  cbu_zero_det #(.W(DATA_W), .SEG_W(SEG_W)) u_opnd_zero (
    .vec_i  (reg_opnd_i),
    .zero_o (opnd_zero)
  );

  always_comb begin
    taken_o = 1'b0;
    case (br_type_i)
      BR_ALWAYS:  taken_o = 1'b1;
      BR_ZERO:    taken_o = opnd_zero;
      BR_NONZERO: taken_o = ~opnd_zero;
      BR_COND:    taken_o = cond_pass;
      default:    taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk
  import cbu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [DATA_W-1:0] alu_res_i,
  input logic              alu_cout_i,
  input logic              alu_ovf_i,
  input logic              flag_set_i,
  input logic [CC_W-1:0]   cond_i,
  input logic [BR_W-1:0]   br_type_i,
  input logic [DATA_W-1:0] reg_opnd_i,
  input logic              taken_o,
  input nzvc_t             flags_q
);
  AST_N_TRACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_set_i |=> (flags_q.n == $past(alu_res_i[DATA_W-1]))); // R1
  AST_Z_TRACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_set_i |=> (flags_q.z == ($past(alu_res_i) == '0))); // R1
  AST_CV_TRACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_set_i |=> (flags_q.c == $past(alu_cout_i)) && (flags_q.v == $past(alu_ovf_i))); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !flag_set_i |=> $stable(flags_q)); // R3
  AST_ALWAYS_BR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_type_i == BR_ALWAYS) |-> taken_o); // R8
  AST_ZERO_BR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_type_i == BR_ZERO) |-> (taken_o == (reg_opnd_i == '0))); // R8
  AST_NONZERO_BR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_type_i == BR_NONZERO) |-> (taken_o == (reg_opnd_i != '0))); // R8
  AST_RESERVED_CC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((br_type_i == BR_COND) && (cond_i > CC_LAST_VALID)) |-> !taken_o); // R7
  AST_EQ_OLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((br_type_i == BR_COND) && (cond_i == CC_EQ)) |-> (taken_o == flags_q.z)); // R9
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_q_n),
  .alu_res_i  (alu_res_i),
  .alu_cout_i (alu_cout_i),
  .alu_ovf_i  (alu_ovf_i),
  .flag_set_i (flag_set_i),
  .cond_i     (cond_i),
  .br_type_i  (br_type_i),
  .reg_opnd_i (reg_opnd_i),
  .taken_o    (taken_o),
  .flags_q    (flags_q)
);

// File: tb/cond_branch_unit_tb_top.sv
module cond_branch_unit_tb_top;
  localparam int DW = 64;
  localparam int NV = 23;
  localparam int VW = DW + 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] alu_res_i;
  logic          alu_cout_i;
  logic          alu_ovf_i;
  logic          flag_set_i;
  logic [3:0]    cond_i;
  logic [2:0]    br_type_i;
  logic [DW-1:0] reg_opnd_i;
  logic          taken_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cond_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .alu_res_i(alu_res_i), .alu_cout_i(alu_cout_i),
    .alu_ovf_i(alu_ovf_i), .flag_set_i(flag_set_i), .cond_i(cond_i),
    .br_type_i(br_type_i), .reg_opnd_i(reg_opnd_i), .taken_o(taken_o)
  );

  // {result, carry, overflow, condition code, expected taken}
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {64'h0, 1'b1, 1'b0, 4'd0, 1'b1},
    {64'h0, 1'b1, 1'b0, 4'd1, 1'b0},
    {64'h0, 1'b1, 1'b0, 4'd2, 1'b1},
    {64'h0, 1'b1, 1'b0, 4'd5, 1'b1},
    {64'h0, 1'b1, 1'b0, 4'd4, 1'b0},
    {64'h0, 1'b1, 1'b0, 4'd9, 1'b1},
    {64'h0, 1'b1, 1'b0, 4'd8, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, 4'd7, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, 4'd4, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, 4'd6, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, 4'd3, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 1'b0, 4'd5, 1'b0},
    {64'h5, 1'b0, 1'b0, 4'd8, 1'b1},
    {64'h5, 1'b0, 1'b0, 4'd9, 1'b0},
    {64'h5, 1'b0, 1'b0, 4'd3, 1'b1},
    {64'h5, 1'b0, 1'b0, 4'd2, 1'b0},
    {64'h5, 1'b0, 1'b0, 4'd4, 1'b0},
    {64'h8000_0000_0000_0000, 1'b0, 1'b1, 4'd7, 1'b0},
    {64'h8000_0000_0000_0000, 1'b0, 1'b1, 4'd6, 1'b1},
    {64'h8000_0000_0000_0000, 1'b0, 1'b1, 4'd8, 1'b1},
    {64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 4'd7, 1'b1},
    {64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 4'd9, 1'b1},
    {64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 4'd4, 1'b1}
  };

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: taken=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic write_flags(input logic [DW-1:0] r, input logic c, input logic v);
    @(negedge clk);
    alu_res_i = r; alu_cout_i = c; alu_ovf_i = v; flag_set_i = 1'b1;
    br_type_i = 3'd0;
    @(negedge clk);
    flag_set_i = 1'b0;
  endtask

  task automatic probe(input logic [2:0] bt, input logic [3:0] cc, input logic [DW-1:0] op);
    br_type_i = bt; cond_i = cc; reg_opnd_i = op;
    #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: taken=%0b expected=finished run", taken_o);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    alu_res_i = '0; alu_cout_i = 1'b0; alu_ovf_i = 1'b0; flag_set_i = 1'b0;
    cond_i = '0; br_type_i = '0; reg_opnd_i = '0;
    do_reset();

    // R4: cleared bits after reset
    probe(3'd4, 4'd0, '0); check(taken_o, 1'b0, "R4", "EQ after reset");
    probe(3'd4, 4'd1, '0); check(taken_o, 1'b1, "R4", "NE after reset");
    probe(3'd4, 4'd3, '0); check(taken_o, 1'b1, "R4", "LO after reset");
    probe(3'd4, 4'd6, '0); check(taken_o, 1'b1, "R4", "GE after reset");
    probe(3'd4, 4'd7, '0); check(taken_o, 1'b0, "R4", "LT after reset");

    // table walk: R1 R2 via R5 (signed) and R6 (unsigned) predicates
    for (int i = 0; i < NV; i++) begin
      logic [3:0] cc;
      cc = VEC[i][4:1];
      write_flags(VEC[i][VW-1:7], VEC[i][6], VEC[i][5]);
      probe(3'd4, cc, '0);
      check(taken_o, VEC[i][0], (cc inside {4'd2, 4'd3, 4'd4, 4'd5}) ? "R6" : "R5",
            $sformatf("vector %0d code %0d", i, cc));
    end

    // R3: flags hold without write enable
    write_flags(64'h0, 1'b1, 1'b0);
    @(negedge clk);
    alu_res_i = 64'h5; alu_cout_i = 1'b0; alu_ovf_i = 1'b1; flag_set_i = 1'b0;
    @(negedge clk);
    probe(3'd4, 4'd0, '0); check(taken_o, 1'b1, "R3", "EQ kept after ignored result");
    probe(3'd4, 4'd2, '0); check(taken_o, 1'b1, "R3", "HS kept after ignored result");
    probe(3'd4, 4'd6, '0); check(taken_o, 1'b1, "R3", "GE kept after ignored overflow");

    // R7: reserved codes
    for (int k = 10; k < 16; k++) begin
      probe(3'd4, 4'(k), '0); check(taken_o, 1'b0, "R7", $sformatf("code %0d with Z=1", k));
    end
    write_flags(64'h5, 1'b0, 1'b0);
    probe(3'd4, 4'd15, '0); check(taken_o, 1'b0, "R7", "code 15 with Z=0");

    // R8: branch kinds, flags now Z=0
    probe(3'd1, 4'd0, 64'h1); check(taken_o, 1'b1, "R8", "always");
    probe(3'd2, 4'd0, 64'h0); check(taken_o, 1'b1, "R8", "on-zero, zero operand");
    probe(3'd2, 4'd0, 64'h1); check(taken_o, 1'b0, "R8", "on-zero, bit0 set");
    probe(3'd2, 4'd0, 64'h8000_0000_0000_0000); check(taken_o, 1'b0, "R8", "on-zero, bit63 set");
    probe(3'd3, 4'd0, 64'h0); check(taken_o, 1'b0, "R8", "on-nonzero, zero operand");
    probe(3'd3, 4'd0, 64'h0000_0100_0000_0000); check(taken_o, 1'b1, "R8", "on-nonzero, bit40 set");
    for (int b = 5; b < 8; b++) begin
      probe(3'(b), 4'd1, 64'h0); check(taken_o, 1'b0, "R8", $sformatf("kind %0d", b));
    end
    probe(3'd0, 4'd1, 64'h0); check(taken_o, 1'b0, "R8", "kind none");

    // R9: write and EQ branch in the same cycle (stored Z=0, new result zero)
    @(negedge clk);
    alu_res_i = 64'h0; alu_cout_i = 1'b1; alu_ovf_i = 1'b0; flag_set_i = 1'b1;
    probe(3'd4, 4'd0, '0); check(taken_o, 1'b0, "R9", "EQ uses old Z in write cycle");
    @(negedge clk);
    flag_set_i = 1'b0;
    probe(3'd4, 4'd0, '0); check(taken_o, 1'b1, "R9", "EQ uses new Z next cycle");

    // R4: reset in mid-run clears the stored bits
    do_reset();
    probe(3'd4, 4'd0, '0); check(taken_o, 1'b0, "R4", "EQ after second reset");
    probe(3'd4, 4'd2, '0); check(taken_o, 1'b0, "R4", "HS after second reset");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule